// File: doc/BRIEF.md
# Crossbar Pin Multiplexer

This block is a register-configured crossbar between a chip's external pads and its internal signals. On the pad side, every pad has a selector register naming the internal source that drives it. That source can be one bit of a GPIO port or a peripheral transmit line. The pad's output value and output enable follow the chosen source. On the sink side, every internal input has its own selector register naming the pad that feeds it. These inputs are GPIO bits and peripheral receive lines. The two directions are configured independently of each other.

Because routing is independent in each direction, one pad can feed several sinks. A button pad can, for example, feed one GPIO bit set up for rising edges and another set up for falling edges. A pad that is driven as an output can also be read back by a sink, as long as its input enable is set. Each pad also has a control register with an input-enable bit and two pull bits. The pull bits only come out as control signals; the pads' analog behaviour is outside this block.

Configuration goes through a simple write port with a combinational read port. Routing is combinational from the registered selectors, so a write is seen on the outputs after the clock edge that captures it.

Top module: `pin_crossbar`

## Requirements
- R1: After synchronous reset, every selector and control register reads 0. Every pad has pad_oe=0 and pad_out=0, and every sink output (gpio_rcv, periph_snk) is 0.
- R2: The pad selector for pad i is at byte address 8*i. Its code picks the pad's source as follows:
  - 0: unconnected, so pad_oe=0 and pad_out=0.
  - 1+16*p+b: GPIO bit b of port p, i.e. gpio_drv/gpio_drv_en bit 16*p+b. The pad's output and enable copy that bit.
  - 33+k: peripheral source periph_src[k], with pad_oe=1 always.
  - Any code above the last valid one: unconnected.
- R3: The pad control register for pad i is at 8*i+4. Bit 0 is the input enable, bit 1 drives pad_pu[i] and bit 2 drives pad_pd[i].
- R4: The selector for GPIO sink bit b of port p is at 0x100+64*p+4*b, and it drives gpio_rcv[16*p+b]. Code 0 gives a constant 0; code 1+j selects pad j.
- R5: A sink that selects pad j receives pad_in[j] only while the input enable of pad j is 1; otherwise the sink reads 0.
- R6: Several sinks may select the same pad, and each of them follows that pad's input independently.
- R7: When a pad is driven as an output with its input enable set, a sink selecting that pad sees the driven level on pad_in.
- R8: The selector for peripheral sink k is at 0x200+4*k and drives periph_snk[k]. It uses the same codes as R4.
- R9: An address that is unmapped or not a multiple of 4 reads as 0, and a write to it changes no register and no output.
- R10: A write takes effect at the clock edge that captures it. The outputs keep the old routing before that edge and show the new routing right after it. reg_rdata returns the stored value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| gpio_drv | input | 32 | Output values of the GPIO bits |
| gpio_drv_en | input | 32 | Output enables of the GPIO bits |
| gpio_rcv | output | 32 | Routed inputs to the GPIO bits |
| periph_src | input | 1 | Peripheral transmit sources |
| periph_snk | output | 1 | Peripheral receive sinks |
| pad_in | input | 16 | Level seen at each pad |
| pad_out | output | 16 | Value driven to each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_pu | output | 16 | Pull-up request for each pad |
| pad_pd | output | 16 | Pull-down request for each pad |

## Verification
Two functions can fall in the same cycle: a selector write is being captured while the pad input it concerns is changing. The bench sets up that case in two ways. First, it enables input on a pad, drives the pad high and issues a sink-selector write for that pad in the same cycle. It then checks that the sink is still 0 before the edge and 1 right after it. Second, it loops a driven pad back through pad_in to a second GPIO sink, which checks that readback and output routing work together in one configuration.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 16;
    localparam int PAD_STRIDE  = 8;
    localparam int CTL_OFFSET  = 4;
    localparam int SNK_BASE    = 256;
    localparam int PORT_STRIDE = 64;
    localparam int WORD_STRIDE = 4;
    localparam int PSNK_BASE   = 512;
    localparam int SRC_GPIO_BASE = 1;
    localparam int SNK_PAD_BASE  = 1;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PAD_SEL,
        RK_PAD_CTL,
        RK_GPIO_SNK,
        RK_PERIPH_SNK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_hit_t;

    typedef struct packed {
        logic pull_dn;
        logic pull_up;
        logic in_en;
    } pad_ctl_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_pads,
                                             input int n_ports,
                                             input int bits_pp,
                                             input int n_psnk);
        reg_hit_t h;
        int ai;
        int off;
        int p;
        int b;
        h.kind = RK_NONE;
        h.idx  = '0;
        ai = int'(a);
        if (ai % WORD_STRIDE == 0) begin
            if (ai < n_pads * PAD_STRIDE) begin
                h.kind = ((ai % PAD_STRIDE) == CTL_OFFSET) ? RK_PAD_CTL : RK_PAD_SEL;
                h.idx  = 8'(ai / PAD_STRIDE);
            end else if (ai >= SNK_BASE && ai < SNK_BASE + n_ports * PORT_STRIDE) begin
                off = ai - SNK_BASE;
                p   = off / PORT_STRIDE;
                b   = (off % PORT_STRIDE) / WORD_STRIDE;
                if (b < bits_pp) begin
                    h.kind = RK_GPIO_SNK;
                    h.idx  = 8'(p * bits_pp + b);
                end
            end else if (ai >= PSNK_BASE && ai < PSNK_BASE + n_psnk * WORD_STRIDE) begin
                h.kind = RK_PERIPH_SNK;
                h.idx  = 8'((ai - PSNK_BASE) / WORD_STRIDE);
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/pxb_regs.sv
module pxb_regs
    import pxb_pkg::*;
#(
    parameter int NUM_PADS   = 16,
    parameter int GPIO_PORTS = 2,
    parameter int GPIO_BITS  = 16,
    parameter int NUM_PSNK   = 1,
    parameter int SRC_SEL_W  = 6,
    parameter int SNK_SEL_W  = 5,
    localparam int NGPIO     = GPIO_PORTS * GPIO_BITS
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_wr,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic [NUM_PADS-1:0][SRC_SEL_W-1:0] pad_sel,
    output pad_ctl_t [NUM_PADS-1:0]            pad_ctl,
    output logic [NGPIO-1:0][SNK_SEL_W-1:0]    gsnk_sel,
    output logic [NUM_PSNK-1:0][SNK_SEL_W-1:0] psnk_sel
);

    reg_hit_t hit;
    logic     unused_wdata;

    assign hit = decode_addr(reg_addr, NUM_PADS, GPIO_PORTS, GPIO_BITS, NUM_PSNK);
    assign unused_wdata = ^reg_wdata;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        always_ff @(posedge clk) begin
            if (rst) begin
                pad_sel[i] <= '0;
                pad_ctl[i] <= '0;
            end else if (reg_wr && hit.idx == 8'(i)) begin
                if (hit.kind == RK_PAD_SEL)
                    pad_sel[i] <= reg_wdata[SRC_SEL_W-1:0];
                if (hit.kind == RK_PAD_CTL)
                    pad_ctl[i] <= reg_wdata[$bits(pad_ctl_t)-1:0];
            end
        end
    end

    for (genvar s = 0; s < NGPIO; s++) begin : g_gsnk
        always_ff @(posedge clk) begin
            if (rst)
                gsnk_sel[s] <= '0;
            else if (reg_wr && hit.kind == RK_GPIO_SNK && hit.idx == 8'(s))
                gsnk_sel[s] <= reg_wdata[SNK_SEL_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_PSNK; k++) begin : g_psnk
        always_ff @(posedge clk) begin
            if (rst)
                psnk_sel[k] <= '0;
            else if (reg_wr && hit.kind == RK_PERIPH_SNK && hit.idx == 8'(k))
                psnk_sel[k] <= reg_wdata[SNK_SEL_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_PADS; i++) begin
            if (hit.idx == 8'(i) && hit.kind == RK_PAD_SEL)
                reg_rdata = DATA_W'(pad_sel[i]);
            if (hit.idx == 8'(i) && hit.kind == RK_PAD_CTL)
                reg_rdata = DATA_W'(pad_ctl[i]);
        end
        for (int s = 0; s < NGPIO; s++)
            if (hit.idx == 8'(s) && hit.kind == RK_GPIO_SNK)
                reg_rdata = DATA_W'(gsnk_sel[s]);
        for (int k = 0; k < NUM_PSNK; k++)
            if (hit.idx == 8'(k) && hit.kind == RK_PERIPH_SNK)
                reg_rdata = DATA_W'(psnk_sel[k]);
    end

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (hit.kind == RK_NONE) |-> (reg_rdata == '0));

    a_r10_pad0_write_lands: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0) |=> (pad_sel[0] == $past(reg_wdata[SRC_SEL_W-1:0])));

endmodule

// File: rtl/pxb_out_route.sv
module pxb_out_route
    import pxb_pkg::*;
#(
    parameter int NUM_PADS  = 16,
    parameter int NGPIO     = 32,
    parameter int NUM_PSRC  = 1,
    parameter int SRC_SEL_W = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_PADS-1:0][SRC_SEL_W-1:0] pad_sel,
    input  logic [NGPIO-1:0]                   gpio_drv,
    input  logic [NGPIO-1:0]                   gpio_drv_en,
    input  logic [NUM_PSRC-1:0]                periph_src,
    output logic [NUM_PADS-1:0]                pad_out,
    output logic [NUM_PADS-1:0]                pad_oe
);

    localparam int PSRC_BASE = SRC_GPIO_BASE + NGPIO;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        always_comb begin
            pad_out[i] = 1'b0;
            pad_oe[i]  = 1'b0;
            for (int s = 0; s < NGPIO; s++) begin
                if (pad_sel[i] == SRC_SEL_W'(SRC_GPIO_BASE + s)) begin
                    pad_out[i] = gpio_drv[s];
                    pad_oe[i]  = gpio_drv_en[s];
                end
            end
            for (int k = 0; k < NUM_PSRC; k++) begin
                if (pad_sel[i] == SRC_SEL_W'(PSRC_BASE + k)) begin
                    pad_out[i] = periph_src[k];
                    pad_oe[i]  = 1'b1;
                end
            end
        end

        a_r2_idle_pad_quiet: assert property (@(posedge clk) disable iff (rst)
            (pad_sel[i] == '0) |-> (!pad_oe[i] && !pad_out[i]));

        a_r2_periph_always_enabled: assert property (@(posedge clk) disable iff (rst)
            (pad_sel[i] == SRC_SEL_W'(PSRC_BASE)) |-> pad_oe[i]);
    end

endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route
    import pxb_pkg::*;
#(
    parameter int NUM_PADS  = 16,
    parameter int NUM_SINKS = 33,
    parameter int SNK_SEL_W = 5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_SINKS-1:0][SNK_SEL_W-1:0] sink_sel,
    input  logic [NUM_PADS-1:0]                 pad_in,
    input  logic [NUM_PADS-1:0]                 pad_ie,
    output logic [NUM_SINKS-1:0]                sink_val
);

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
        always_comb begin
            sink_val[s] = 1'b0;
            for (int j = 0; j < NUM_PADS; j++)
                if (sink_sel[s] == SNK_SEL_W'(SNK_PAD_BASE + j))
                    sink_val[s] = pad_in[j] & pad_ie[j];
        end

        a_r4_unrouted_sink_zero: assert property (@(posedge clk) disable iff (rst)
            (sink_sel[s] == '0) |-> !sink_val[s]);
    end

    a_r5_no_enabled_input: assert property (@(posedge clk) disable iff (rst)
        ((pad_in & pad_ie) == '0) |-> (sink_val == '0));

endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
    import pxb_pkg::*;
#(
    parameter int NUM_PADS   = 16,
    parameter int GPIO_PORTS = 2,
    parameter int GPIO_BITS  = 16,
    parameter int NUM_PSRC   = 1,
    parameter int NUM_PSNK   = 1,
    localparam int NGPIO     = GPIO_PORTS * GPIO_BITS,
    localparam int SRC_SEL_W = $clog2(SRC_GPIO_BASE + NGPIO + NUM_PSRC),
    localparam int SNK_SEL_W = $clog2(SNK_PAD_BASE + NUM_PADS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NGPIO-1:0]     gpio_drv,
    input  logic [NGPIO-1:0]     gpio_drv_en,
    output logic [NGPIO-1:0]     gpio_rcv,
    input  logic [NUM_PSRC-1:0]  periph_src,
    output logic [NUM_PSNK-1:0]  periph_snk,
    input  logic [NUM_PADS-1:0]  pad_in,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe,
    output logic [NUM_PADS-1:0]  pad_pu,
    output logic [NUM_PADS-1:0]  pad_pd
);

    localparam int NUM_SINKS = NGPIO + NUM_PSNK;

    logic [NUM_PADS-1:0][SRC_SEL_W-1:0] pad_sel;
    pad_ctl_t [NUM_PADS-1:0]            pad_ctl;
    logic [NGPIO-1:0][SNK_SEL_W-1:0]    gsnk_sel;
    logic [NUM_PSNK-1:0][SNK_SEL_W-1:0] psnk_sel;
    logic [NUM_SINKS-1:0][SNK_SEL_W-1:0] sink_sel;
    logic [NUM_SINKS-1:0]               sink_val;
    logic [NUM_PADS-1:0]                pad_ie;

    pxb_regs #(
        .NUM_PADS  (NUM_PADS),
        .GPIO_PORTS(GPIO_PORTS),
        .GPIO_BITS (GPIO_BITS),
        .NUM_PSNK  (NUM_PSNK),
        .SRC_SEL_W (SRC_SEL_W),
        .SNK_SEL_W (SNK_SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pad_sel  (pad_sel),
        .pad_ctl  (pad_ctl),
        .gsnk_sel (gsnk_sel),
        .psnk_sel (psnk_sel)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_ctl
        assign pad_ie[i] = pad_ctl[i].in_en;
        assign pad_pu[i] = pad_ctl[i].pull_up;
        assign pad_pd[i] = pad_ctl[i].pull_dn;
    end

    pxb_out_route #(
        .NUM_PADS (NUM_PADS),
        .NGPIO    (NGPIO),
        .NUM_PSRC (NUM_PSRC),
        .SRC_SEL_W(SRC_SEL_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .pad_sel    (pad_sel),
        .gpio_drv   (gpio_drv),
        .gpio_drv_en(gpio_drv_en),
        .periph_src (periph_src),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign sink_sel = {psnk_sel, gsnk_sel};

    pxb_in_route #(
        .NUM_PADS (NUM_PADS),
        .NUM_SINKS(NUM_SINKS),
        .SNK_SEL_W(SNK_SEL_W)
    ) u_in (
        .clk     (clk),
        .rst     (rst),
        .sink_sel(sink_sel),
        .pad_in  (pad_in),
        .pad_ie  (pad_ie),
        .sink_val(sink_val)
    );

    assign gpio_rcv   = sink_val[NGPIO-1:0];
    assign periph_snk = sink_val[NUM_SINKS-1:NGPIO];

    a_r1_reset_clears_outputs: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0));

endmodule

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] gpio_drv = '0;
    logic [31:0] gpio_drv_en = '0;
    logic [31:0] gpio_rcv;
    logic [0:0]  periph_src = '0;
    logic [0:0]  periph_snk;
    logic [15:0] pad_in;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [15:0] pad_pu;
    logic [15:0] pad_pd;
    logic [15:0] ext = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    pin_crossbar u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_drv(gpio_drv), .gpio_drv_en(gpio_drv_en), .gpio_rcv(gpio_rcv),
        .periph_src(periph_src), .periph_snk(periph_snk),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 pad_out", 32'(pad_out), 0);
        check("R1 gpio_rcv", gpio_rcv, 0);
        check("R1 periph_snk", 32'(periph_snk), 0);
        rd(12'h000, d); check("R1 pad0 sel", 32'(d), 0);
        rd(12'h104, d); check("R1 gpio sink 1 sel", 32'(d), 0);
    endtask

    task automatic t_gpio_source;
        logic [15:0] d;
        wr(12'h018, 16'd22);
        gpio_drv[21] = 1'b1; gpio_drv_en[21] = 1'b1; #1;
        check("R2 pad3 out high", 32'(pad_out[3]), 1);
        check("R2 pad3 oe", 32'(pad_oe[3]), 1);
        gpio_drv[21] = 1'b0; #1;
        check("R2 pad3 out low", 32'(pad_out[3]), 0);
        gpio_drv_en[21] = 1'b0; #1;
        check("R2 pad3 oe follows source", 32'(pad_oe[3]), 0);
        rd(12'h018, d); check("R10 pad3 sel readback", 32'(d), 22);
    endtask

    task automatic t_periph_source;
        wr(12'h000, 16'd33);
        periph_src = 1'b1; #1;
        check("R2 pad0 periph out", 32'(pad_out[0]), 1);
        check("R2 pad0 periph oe", 32'(pad_oe[0]), 1);
        periph_src = 1'b0; #1;
        check("R2 pad0 periph oe stays", 32'(pad_oe[0]), 1);
    endtask

    task automatic t_bad_code;
        gpio_drv = '1; gpio_drv_en = '1; periph_src = 1'b1;
        wr(12'h028, 16'd40); #1;
        check("R2 pad5 bad code oe", 32'(pad_oe[5]), 0);
        check("R2 pad5 bad code out", 32'(pad_out[5]), 0);
        gpio_drv = '0; gpio_drv_en = '0; periph_src = 1'b0; #1;
    endtask

    task automatic t_control;
        logic [15:0] d;
        wr(12'h03C, 16'h0002);
        check("R3 pad7 pull-up", 32'(pad_pu[7]), 1);
        check("R3 pad7 pull-down", 32'(pad_pd[7]), 0);
        rd(12'h03C, d); check("R3 pad7 ctl readback", 32'(d), 2);
        wr(12'h03C, 16'h0004);
        check("R3 pad7 pull-down set", 32'(pad_pd), 32'h0080);
        check("R3 pad7 pull-up clear", 32'(pad_pu), 0);
    endtask

    task automatic t_sink_enable;
        ext[9] = 1'b1;
        wr(12'h108, 16'd10);
        check("R5 sink gated without input enable", 32'(gpio_rcv[2]), 0);
        wr(12'h04C, 16'h0001);
        check("R4 gpio bit 2 sees pad9", 32'(gpio_rcv[2]), 1);
    endtask

    task automatic t_alias;
        wr(12'h140, 16'd10);
        check("R6 alias port1 bit0 high", 32'(gpio_rcv[16]), 1);
        ext[9] = 1'b0; #1;
        check("R6 alias port1 bit0 low", 32'(gpio_rcv[16]), 0);
        check("R6 alias port0 bit2 low", 32'(gpio_rcv[2]), 0);
        ext[9] = 1'b1; #1;
        check("R6 both aliases high", 32'({gpio_rcv[16], gpio_rcv[2]}), 3);
    endtask

    task automatic t_readback;
        wr(12'h020, 16'd7);
        wr(12'h024, 16'h0001);
        wr(12'h11C, 16'd5);
        gpio_drv[6] = 1'b1; gpio_drv_en[6] = 1'b1; ext[4] = 1'b0; #1;
        check("R7 readback of driven pad high", 32'(gpio_rcv[7]), 1);
        gpio_drv[6] = 1'b0; ext[4] = 1'b1; #1;
        check("R7 readback of driven pad low", 32'(gpio_rcv[7]), 0);
        ext[4] = 1'b0;
    endtask

    task automatic t_periph_sink;
        ext[1] = 1'b1;
        wr(12'h00C, 16'h0001);
        wr(12'h200, 16'd2);
        check("R8 periph sink from pad1", 32'(periph_snk), 1);
        ext[1] = 1'b0; #1;
        check("R8 periph sink follows pad1", 32'(periph_snk), 0);
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        logic [31:0] snap;
        snap = gpio_rcv;
        wr(12'h180, 16'd5);
        rd(12'h180, d); check("R9 beyond ports reads 0", 32'(d), 0);
        wr(12'h204, 16'd3);
        rd(12'h204, d); check("R9 beyond periph sinks reads 0", 32'(d), 0);
        wr(12'h101, 16'd10);
        rd(12'h100, d); check("R9 misaligned write ignored", 32'(d), 0);
        rd(12'h080, d); check("R9 beyond pads reads 0", 32'(d), 0);
        check("R9 sinks unchanged", gpio_rcv, snap);
    endtask

    task automatic t_same_cycle;
        ext[9] = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h10C; reg_wdata = 16'd10; ext[9] = 1'b1;
        #1;
        check("R10 old routing before edge", 32'(gpio_rcv[3]), 0);
        @(posedge clk);
        #1;
        check("R10 new routing after edge", 32'(gpio_rcv[3]), 1);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_gpio_source();
        t_periph_source();
        t_bad_code();
        t_control();
        t_sink_enable();
        t_alias();
        t_readback();
        t_periph_sink();
        t_unmapped();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule